// File: doc/BRIEF.md
# PSK/FSK Subcarrier Modulator

This block turns a stream of NRZ data bits into one modulator control line derived from the RF carrier clock. Every cycle of `clk` is one carrier period. In the two phase-shift-keying modes, a square subcarrier at a selectable fraction of the carrier (divide by 2, 4 or 8) is produced, and its phase is inverted according to the data. One mode inverts the phase for every 1 bit. The other inverts it only when the data goes from 0 to 1. In the frequency-shift-keying mode, the line carries a square wave whose period is 5 carrier cycles for a 0 bit and 8 carrier cycles for a 1 bit.

The surrounding logic supplies the data bit and a one-cycle `bit_strobe` that marks the last carrier cycle of each bit. The data is sampled only in a strobe cycle. The bit rate is produced outside this block, and so is any line coding. In the phase-shift-keying modes the bit length must be a whole number of subcarrier periods. Because of that, the strobe always falls on the last cycle of a subcarrier period, and phase inversions start on a period boundary.

Top module: `subcarrier_mod`

## Requirements
- R1: `rst_n` is a synchronous, active-low reset. It clears the subcarrier phase, the remembered previous bit and both counters, and it selects the 5-cycle FSK rate. In the first cycle after reset, `mod_out` is 1 in modes 00, 01 and 10.
- R2: In modes 00 and 01, the subcarrier period is set by `sc_sel`: 2 cycles for 00, 4 cycles for 01, and 8 cycles for 10 and 11. With no inversion pending, the subcarrier is high for the first half of each period and low for the second half, counted from the first cycle after reset.
- R3: In mode 00, a strobe cycle with `data_in`=1 inverts the subcarrier phase starting in the next cycle. A strobe cycle with `data_in`=0 leaves the phase unchanged.
- R4: In mode 01, a strobe cycle inverts the phase only if `data_in`=1 and the bit sampled at the previous strobe was 0. The previous bit counts as 0 after reset.
- R5: In modes 00 and 01, `bit_strobe` may be high only in the last cycle of a subcarrier period. Every inversion therefore begins at the start of a period.
- R6: In mode 10, a 0 bit produces a wave with a 5-cycle period: 2 cycles high, then 3 cycles low. A 1 bit produces a wave with an 8-cycle period: 4 cycles high, then 4 cycles low.
- R7: In mode 10, the bit sampled in a strobe cycle selects the rate from the next cycle on. That next cycle starts a new period, beginning high, whatever the phase the wave had reached.
- R8: Mode 11 holds `mod_out` at 0.
- R9: `data_in` has no effect in cycles where `bit_strobe` is 0. The phase and the FSK rate keep their values between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RF carrier clock; one cycle is one carrier period |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 00 PSK flip on 1, 01 PSK flip on rising data, 10 FSK, 11 off |
| sc_sel | input | 2 | Subcarrier divide: 00 by 2, 01 by 4, 10/11 by 8 |
| data_in | input | 1 | NRZ data bit, sampled in strobe cycles |
| bit_strobe | input | 1 | High in the last carrier cycle of each bit |
| mod_out | output | 1 | Modulator control line, 1 means modulator on |

## Verification
Some rules are checked by the assertions on every cycle:
- the phase flips exactly in the cycle after a qualifying strobe, and holds in every other cycle;
- the edge rule's memory of the previous bit blocks a second flip;
- the subcarrier counter wraps at the selected period;
- the FSK counter restarts at zero with the sampled rate;
- strobes in the PSK modes land only on the last cycle of a period.

The whole output waveform can only be shown by the bench's scenarios. These scenarios cover:
- the high and low run lengths for each divider;
- the accumulated phase over long runs of random bits, for both flip rules;
- the FSK periods, including strobes that fall mid-period;
- noise on `data_in` between strobes;
- the silent fourth mode.

// File: rtl/subcarrier_mod_pkg.sv
// Package: shared types for the subcarrier modulator.
// Assumes mode_sel keeps the fixed 2-bit encoding below.
package subcarrier_mod_pkg;

    typedef enum logic [1:0] {
        MODE_PSK_ONE  = 2'b00,  // invert phase on every 1 bit
        MODE_PSK_RISE = 2'b01,  // invert phase on a 0 -> 1 data change
        MODE_FSK      = 2'b10,  // two-rate frequency keying
        MODE_OFF      = 2'b11   // output held low
    } mod_mode_e;

    // Returns 1 when the mode uses the phase-keyed subcarrier.
    function automatic logic is_psk(input mod_mode_e m);
        return (m == MODE_PSK_ONE) || (m == MODE_PSK_RISE);
    endfunction

endpackage

// File: rtl/sc_divider.sv
// Module: sc_divider
// Makes the square PSK subcarrier from the carrier clock with one of three
// divide ratios. The wave is high in the first half of each period.
// Assumes: every divide ratio is even and no larger than DIV_C.
// sc_last marks the last cycle of a period. The counter stays at zero
// while run is low.
module sc_divider #(
    parameter int DIV_A = 2,
    parameter int DIV_B = 4,
    parameter int DIV_C = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sc_sel,
    output logic       sc_wave,
    output logic       sc_last
);
    localparam int CNT_W = $clog2(DIV_C + 1);
    localparam logic [CNT_W-1:0] A_M1   = CNT_W'(DIV_A - 1);
    localparam logic [CNT_W-1:0] B_M1   = CNT_W'(DIV_B - 1);
    localparam logic [CNT_W-1:0] C_M1   = CNT_W'(DIV_C - 1);
    localparam logic [CNT_W-1:0] A_HALF = CNT_W'(DIV_A / 2);
    localparam logic [CNT_W-1:0] B_HALF = CNT_W'(DIV_B / 2);
    localparam logic [CNT_W-1:0] C_HALF = CNT_W'(DIV_C / 2);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] half_val;

    // Pick the terminal count and the half-period point for the selected ratio.
    always_comb begin
        unique case (sc_sel)
            2'b00:   begin last_val = A_M1; half_val = A_HALF; end
            2'b01:   begin last_val = B_M1; half_val = B_HALF; end
            default: begin last_val = C_M1; half_val = C_HALF; end
        endcase
    end

    // Count carrier cycles within one subcarrier period.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!run)          cnt <= '0;
        else if (cnt >= last_val) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign sc_last = (cnt >= last_val);
    assign sc_wave = (cnt < half_val);

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sc_last) |=> (cnt == '0))
        else $error("subcarrier counter did not wrap");

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0))
        else $error("subcarrier counter moved while idle");

endmodule

// File: rtl/psk_phase.sv
// Module: psk_phase
// Holds the PSK phase bit and applies one of two flip rules when a strobe arrives.
// With edge_rule low, each strobed 1 flips the phase. With edge_rule high, only a
// strobed 1 that follows a strobed 0 flips it.
// Assumes: the strobe lasts one cycle and is aligned by the caller to a period end.
module psk_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic edge_rule,
    input  logic strobe,
    input  logic data,
    output logic phase
);
    logic prev_bit;
    logic take;
    logic flip;

    assign take = en && strobe;
    assign flip = take && data && (!edge_rule || !prev_bit);

    // Toggle the phase when the selected rule asks for it.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= 1'b0;
        else if (flip) phase <= ~phase;
    end

    // Remember the last strobed bit for the rising-data rule.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_bit <= 1'b0;
        else if (take) prev_bit <= data;
    end

    // R9
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(phase))
        else $error("phase moved without a strobe");

    // R3
    flip_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !edge_rule && data) |=> (phase != $past(phase)))
        else $error("phase did not flip on strobed 1");

    // R4
    flip_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && edge_rule && data && !prev_bit) |=> (phase != $past(phase)))
        else $error("phase did not flip on rising data");

    // R4
    no_flip_after_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && edge_rule && prev_bit) |=> $stable(phase))
        else $error("phase flipped on repeated 1");

endmodule

// File: rtl/fsk_gen.sv
// Module: fsk_gen
// Generates a two-rate square wave. The bit taken at each strobe selects the
// rate. A 0 bit selects a ZERO_DIV period with ZERO_HIGH high cycles. A 1 bit
// selects a ONE_DIV period with ONE_HIGH high cycles. A strobe also restarts
// the period, so the next cycle is the first high cycle.
// Assumes: the high lengths are shorter than their periods.
module fsk_gen #(
    parameter int ZERO_DIV  = 5,
    parameter int ZERO_HIGH = 2,
    parameter int ONE_DIV   = 8,
    parameter int ONE_HIGH  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic strobe,
    input  logic data,
    output logic wave
);
    localparam int MAX_DIV = (ZERO_DIV > ONE_DIV) ? ZERO_DIV : ONE_DIV;
    localparam int CNT_W   = $clog2(MAX_DIV + 1);
    localparam logic [CNT_W-1:0] Z_M1 = CNT_W'(ZERO_DIV - 1);
    localparam logic [CNT_W-1:0] O_M1 = CNT_W'(ONE_DIV - 1);
    localparam logic [CNT_W-1:0] Z_HI = CNT_W'(ZERO_HIGH);
    localparam logic [CNT_W-1:0] O_HI = CNT_W'(ONE_HIGH);

    logic             rate_one;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] high_len;

    // Look up the period end and high length for the current rate.
    always_comb begin
        last_val = rate_one ? O_M1 : Z_M1;
        high_len = rate_one ? O_HI : Z_HI;
    end

    // Latch the rate from the strobed bit.
    always_ff @(posedge clk) begin
        if (!rst_n)               rate_one <= 1'b0;
        else if (en && strobe)    rate_one <= data;
    end

    // Step the position within the current period and restart it on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (!en)             cnt <= '0;
        else if (strobe)          cnt <= '0;
        else if (cnt >= last_val) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    assign wave = (cnt < high_len);

    // R7
    strobe_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && strobe) |=> ((cnt == '0) && (rate_one == $past(data))))
        else $error("FSK did not restart on strobe");

    // R9
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && strobe) |=> $stable(rate_one))
        else $error("FSK rate moved without a strobe");

    // R6
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !strobe && (cnt >= last_val)) |=> (cnt == '0))
        else $error("FSK period did not wrap");

endmodule

// File: rtl/subcarrier_mod.sv
// Module: subcarrier_mod (top)
// Carrier-clocked modulator. It combines the PSK subcarrier divider, the phase
// flip logic and the FSK generator, and a mux chooses which one drives mod_out.
// Assumes: bit_strobe marks the last carrier cycle of each bit. In the PSK
// modes the bit length is a whole number of subcarrier periods.
module subcarrier_mod
    import subcarrier_mod_pkg::*;
#(
    parameter int PSK_DIV_A = 2,
    parameter int PSK_DIV_B = 4,
    parameter int PSK_DIV_C = 8,
    parameter int FSK_ZERO_DIV  = 5,
    parameter int FSK_ZERO_HIGH = 2,
    parameter int FSK_ONE_DIV   = 8,
    parameter int FSK_ONE_HIGH  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic [1:0] sc_sel,
    input  logic       data_in,
    input  logic       bit_strobe,
    output logic       mod_out
);
    mod_mode_e mode;
    logic      psk_on;
    logic      fsk_on;
    logic      sc_wave;
    logic      sc_last;
    logic      phase;
    logic      fsk_wave;

    assign mode   = mod_mode_e'(mode_sel);
    assign psk_on = is_psk(mode);
    assign fsk_on = (mode == MODE_FSK);

    sc_divider #(
        .DIV_A (PSK_DIV_A),
        .DIV_B (PSK_DIV_B),
        .DIV_C (PSK_DIV_C)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (psk_on),
        .sc_sel  (sc_sel),
        .sc_wave (sc_wave),
        .sc_last (sc_last)
    );

    psk_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (psk_on),
        .edge_rule (mode == MODE_PSK_RISE),
        .strobe    (bit_strobe),
        .data      (data_in),
        .phase     (phase)
    );

    fsk_gen #(
        .ZERO_DIV  (FSK_ZERO_DIV),
        .ZERO_HIGH (FSK_ZERO_HIGH),
        .ONE_DIV   (FSK_ONE_DIV),
        .ONE_HIGH  (FSK_ONE_HIGH)
    ) u_fsk (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (fsk_on),
        .strobe (bit_strobe),
        .data   (data_in),
        .wave   (fsk_wave)
    );

    // Select the source that drives the modulator line for the current mode.
    always_comb begin
        unique case (mode)
            MODE_PSK_ONE, MODE_PSK_RISE: mod_out = sc_wave ^ phase;
            MODE_FSK:                    mod_out = fsk_wave;
            default:                     mod_out = 1'b0;
        endcase
    end

    // R5
    strobe_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psk_on && bit_strobe) |-> sc_last)
        else $error("PSK strobe not at subcarrier period end");

    // R8
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> !mod_out)
        else $error("output active in off mode");

endmodule

// File: tb/subcarrier_mod_tb.sv
// Bench: resets the design for each scenario and checks every cycle.
// Expected outputs come from cycle arithmetic: the position within the period,
// plus a phase or rate derived from the bits that were strobed.
module subcarrier_mod_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [1:0] sc_sel = 2'b00;
    logic       data_in = 1'b0;
    logic       bit_strobe = 1'b0;
    logic       mod_out;

    int n_checks = 0;
    int n_errors = 0;
    int t_g = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    subcarrier_mod u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .sc_sel     (sc_sel),
        .data_in    (data_in),
        .bit_strobe (bit_strobe),
        .mod_out    (mod_out)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: t=%0d mod_out=%0b expected %0b", tag, t_g, got, exp);
        end
    endtask

    // Apply a reset and leave the bench at the negedge of cycle 0.
    task automatic do_reset(input logic [1:0] m, input logic [1:0] s);
        rst_n = 1'b0; bit_strobe = 1'b0; data_in = 1'b0;
        mode_sel = m; sc_sel = s;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_psk(input logic [1:0] m, input logic [1:0] s, input int k, input int nbits);
        int p = (s == 2'b00) ? 2 : (s == 2'b01) ? 4 : 8;
        int len = p * k;
        logic ph = 1'b0;
        logic prev = 1'b0;
        do_reset(m, s);
        check(mod_out, 1'b1, "R1 reset PSK first cycle");
        for (int t = 0; t < nbits * len; t++) begin
            logic strobe_now;
            logic b;
            t_g = t;
            check(mod_out, logic'((t % p) < p / 2) ^ ph,
                  (m == 2'b00) ? "R3/R2 PSK flip-on-one" : "R4/R2 PSK flip-on-rise");
            strobe_now = ((t % len) == len - 1);
            b = logic'($urandom_range(0, 1));
            bit_strobe = strobe_now;
            data_in = b;  // R9: random noise on non-strobe cycles
            if (strobe_now) begin
                if ((m == 2'b00) ? b : (b && !prev)) ph = ~ph;
                prev = b;
            end
            @(negedge clk);
        end
        bit_strobe = 1'b0;
    endtask

    task automatic run_fsk(input int len, input int nbits);
        logic rate1 = 1'b0;
        int since = 0;
        do_reset(2'b10, 2'b00);
        check(mod_out, 1'b1, "R1 reset FSK first cycle");
        for (int t = 0; t < nbits * len; t++) begin
            int per = rate1 ? 8 : 5;
            int hi = rate1 ? 4 : 2;
            logic strobe_now;
            logic b;
            t_g = t;
            check(mod_out, logic'((since % per) < hi),
                  (since == 0 && t > 0) ? "R7 FSK restart" : "R6 FSK wave");
            strobe_now = ((t % len) == len - 1);
            b = logic'($urandom_range(0, 1));
            bit_strobe = strobe_now;
            data_in = b;
            if (strobe_now) begin
                rate1 = b;
                since = 0;
            end else begin
                since++;
            end
            @(negedge clk);
        end
        bit_strobe = 1'b0;
    endtask

    task automatic run_off(input int ncyc);
        do_reset(2'b11, 2'b00);
        for (int t = 0; t < ncyc; t++) begin
            t_g = t;
            check(mod_out, 1'b0, "R8 off mode");
            bit_strobe = logic'($urandom_range(0, 1));
            data_in = logic'($urandom_range(0, 1));
            @(negedge clk);
        end
        bit_strobe = 1'b0;
    endtask

    initial begin
        #(100000 * 10);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: t=%0d mod_out=%0b expected %0b", t_g, mod_out, 1'bx);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R2 R3 R4 R5 R9: both flip rules, every divider, two bit lengths
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                run_psk(m[1:0], s[1:0], 1, 40);
                run_psk(m[1:0], s[1:0], 3, 30);
            end
        end
        // R6 R7: aligned and misaligned bit lengths
        run_fsk(40, 30);
        run_fsk(13, 40);
        run_fsk(7, 60);
        run_fsk(1, 50);
        // R8
        run_off(64);
        // R1: reset again after off mode, back into PSK
        run_psk(2'b01, 2'b01, 2, 10);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule